// File: doc/BRIEF.md
# Dual-Channel Command I2C Target

This block is the serial front end of a two-channel register device. It listens on an I2C bus as a target, recognises one fixed 7-bit address and decodes a small fixed command set. A write is three bytes: address, instruction and data. The instruction byte picks one of the two channels and sets or clears a shutdown flag. The data byte produces a register write strobe for the picked channel. A read is two bytes: the address, then the value of the currently picked channel. That value is supplied by the surrounding logic on two input buses.

SCL and SDA are sampled by an oversampling system clock. Each line passes through a two-flop synchronizer and a glitch filter. Bus events (START, STOP, SCL rising, SCL falling) are found from the filtered levels. The block drives SDA only through an open-drain enable: when `sda_oe` is high, the pad is pulled low. The channel selection and the shutdown flag are held outputs. A single-cycle strobe announces each instruction byte and each data byte.

Top module: `dpot_i2c_front`

## Requirements
- R1: After reset, `sda_oe`, `sel_ch`, `shdn`, `instr_stb` and `wr_stb` are all 0.
- R2: A START (SDA falls while SCL is high) begins address framing in any state. A STOP (SDA rises while SCL is high) returns the block to idle and releases SDA.
- R3: The address byte is sent MSB first: seven address bits equal to binary 0101111, then R/W, where 1 means read and 0 means write. When the address matches, `sda_oe` is high during the ninth clock.
- R4: When the address does not match, there is no acknowledge. SDA stays released and no strobe fires until the next START or STOP.
- R5: After a write address, the next byte is the instruction. It is acknowledged. Its bit 7 selects the channel (0 selects channel 0, 1 selects channel 1), its bit 6 is the shutdown flag, and bits 5..0 have no effect. `instr_stb` pulses for one cycle, and `sel_ch` and `shdn` take the new values.
- R6: The byte after the instruction is the data byte. It is acknowledged. A one-cycle `wr_stb` carries it on `wr_data` for the channel on `sel_ch`. The strobe fires on the SCL falling edge after the eighth data bit, before the acknowledge clock rises.
- R7: Bytes after the data byte in the same write are not acknowledged and produce no further strobes.
- R8: A write that stops after the instruction byte still updates `sel_ch` and `shdn` for later reads. It issues no `wr_stb`.
- R9: After a read address is acknowledged, the block drives the selected channel's value (`val0_i` or `val1_i`) MSB first, one bit per SCL clock.
- R10: On a read, after 8 bits the block releases SDA and samples the master's acknowledge. On ACK (SDA low) it sends the same value again. On NACK it leaves SDA released until START or STOP.
- R11: A repeated START part way through a byte discards the partial byte and restarts at the address byte.
- R12: A pulse on SCL or SDA that lasts fewer than `GLITCH_CYC` system clocks does not change the filtered level and is not seen as a bit, START or STOP.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, oversampling the bus |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock level from the pad |
| sda_i | input | 1 | Bus data level from the pad |
| sda_oe | output | 1 | 1 pulls the SDA pad low |
| val0_i | input | 8 | Current value of channel 0, returned on reads |
| val1_i | input | 8 | Current value of channel 1, returned on reads |
| sel_ch | output | 1 | Channel selected by the last instruction byte |
| shdn | output | 1 | Shutdown flag from the last instruction byte |
| instr_stb | output | 1 | One-cycle pulse when an instruction byte is taken |
| wr_stb | output | 1 | One-cycle pulse when a data byte is taken |
| wr_data | output | 8 | Data byte that goes with `wr_stb` |

## Verification
The assertions assume that the master changes SDA only while SCL is low, except for START and STOP. They also assume that every SCL phase outlasts the synchronizer and filter delay, so that the filtered events keep the order of the pad events. The stimulus changes SDA a quarter bit time after SCL falls. It holds each SCL phase for two such quarters, well above the filter window. The glitches it injects last only half the filter window, so they never reach the protocol logic.

// File: rtl/dpot_i2c_pkg.sv
package dpot_i2c_pkg;

    localparam int BYTE_W = 8;

    typedef enum logic [2:0] {
        S_IDLE,
        S_ADDR,
        S_INSTR,
        S_DATA,
        S_ACK,
        S_TX,
        S_MACK,
        S_HALT
    } bus_st_t;

    typedef enum logic [1:0] {
        K_ADDR,
        K_INSTR,
        K_DATA
    } byte_kind_t;

endpackage

// File: rtl/i2c_pin_filter.sv
module i2c_pin_filter #(
    parameter int GLITCH_CYC = 12
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_i,
    output logic lvl_o
);
    localparam int CW = $clog2(GLITCH_CYC + 1);

    typedef struct packed {
        logic [1:0]    sync;
        logic          lvl;
        logic [CW-1:0] cnt;
    } flt_t;

    flt_t r_d, r_q;

    always_comb begin
        r_d      = r_q;
        r_d.sync = {r_q.sync[0], pin_i};
        if (r_q.sync[1] == r_q.lvl) begin
            r_d.cnt = '0;
        end else if (r_q.cnt == CW'(GLITCH_CYC - 1)) begin
            r_d.lvl = r_q.sync[1];
            r_d.cnt = '0;
        end else begin
            r_d.cnt = r_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '{sync: 2'b11, lvl: 1'b1, cnt: '0};
        end else begin
            r_q <= r_d;
        end
    end

    assign lvl_o = r_q.lvl;

    // R12: the filtered level only moves to a value the synchronized pin held
    a_r12_follows_sync: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(r_q.lvl) |-> (r_q.lvl == $past(r_q.sync[1])));

endmodule

// File: rtl/i2c_bus_events.sv
module i2c_bus_events (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_l,
    input  logic sda_l,
    output logic ev_rise,
    output logic ev_fall,
    output logic ev_start,
    output logic ev_stop,
    output logic sda_at,
    output logic scl_at
);
    typedef struct packed {
        logic prev_scl;
        logic prev_sda;
        logic rise;
        logic fall;
        logic start;
        logic stop;
        logic sda;
        logic scl;
    } evt_t;

    evt_t e_d, e_q;

    always_comb begin
        e_d          = e_q;
        e_d.prev_scl = scl_l;
        e_d.prev_sda = sda_l;
        e_d.rise     = ~e_q.prev_scl & scl_l;
        e_d.fall     = e_q.prev_scl & ~scl_l;
        e_d.start    = e_q.prev_scl & scl_l & e_q.prev_sda & ~sda_l;
        e_d.stop     = e_q.prev_scl & scl_l & ~e_q.prev_sda & sda_l;
        e_d.sda      = sda_l;
        e_d.scl      = scl_l;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            e_q <= '{prev_scl: 1'b1, prev_sda: 1'b1, rise: 1'b0, fall: 1'b0,
                     start: 1'b0, stop: 1'b0, sda: 1'b1, scl: 1'b1};
        end else begin
            e_q <= e_d;
        end
    end

    assign ev_rise  = e_q.rise;
    assign ev_fall  = e_q.fall;
    assign ev_start = e_q.start;
    assign ev_stop  = e_q.stop;
    assign sda_at   = e_q.sda;
    assign scl_at   = e_q.scl;

endmodule

// File: rtl/dpot_cmd_fsm.sv
module dpot_cmd_fsm
    import dpot_i2c_pkg::*;
#(
    parameter logic [6:0] DEV_ADDR = 7'b0101111
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ev_rise,
    input  logic              ev_fall,
    input  logic              ev_start,
    input  logic              ev_stop,
    input  logic              sda_at,
    input  logic              scl_at,
    input  logic [BYTE_W-1:0] val0_i,
    input  logic [BYTE_W-1:0] val1_i,
    output logic              sda_oe,
    output logic              sel_ch,
    output logic              shdn,
    output logic              instr_stb,
    output logic              wr_stb,
    output logic [BYTE_W-1:0] wr_data
);
    localparam int CNT_W = $clog2(BYTE_W + 1);

    typedef struct packed {
        bus_st_t           st;
        byte_kind_t        kind;
        logic              rd;
        logic [CNT_W-1:0]  cnt;
        logic [BYTE_W-1:0] sh;
        logic              oe;
        logic              mack;
        logic              ch;
        logic              sd;
        logic              istb;
        logic              wstb;
        logic [BYTE_W-1:0] wdat;
    } fsm_t;

    fsm_t n_d, n_q;
    logic [BYTE_W-1:0] tx_val;

    assign tx_val = n_q.ch ? val1_i : val0_i;

    always_comb begin
        n_d      = n_q;
        n_d.istb = 1'b0;
        n_d.wstb = 1'b0;
        if (ev_stop) begin
            n_d.st = S_IDLE;
            n_d.oe = 1'b0;
        end else if (ev_start) begin
            n_d.st  = S_ADDR;
            n_d.cnt = '0;
            n_d.oe  = 1'b0;
        end else begin
            case (n_q.st)
                S_ADDR, S_INSTR, S_DATA: begin
                    if (ev_rise) begin
                        n_d.sh  = {n_q.sh[BYTE_W-2:0], sda_at};
                        n_d.cnt = n_q.cnt + 1'b1;
                    end else if (ev_fall && n_q.cnt == CNT_W'(BYTE_W)) begin
                        n_d.cnt = '0;
                        case (n_q.st)
                            S_ADDR: begin
                                if (n_q.sh[BYTE_W-1:1] == DEV_ADDR) begin
                                    n_d.rd   = n_q.sh[0];
                                    n_d.oe   = 1'b1;
                                    n_d.kind = K_ADDR;
                                    n_d.st   = S_ACK;
                                end else begin
                                    n_d.st = S_HALT;
                                end
                            end
                            S_INSTR: begin
                                n_d.ch   = n_q.sh[BYTE_W-1];
                                n_d.sd   = n_q.sh[BYTE_W-2];
                                n_d.istb = 1'b1;
                                n_d.oe   = 1'b1;
                                n_d.kind = K_INSTR;
                                n_d.st   = S_ACK;
                            end
                            default: begin
                                n_d.wdat = n_q.sh;
                                n_d.wstb = 1'b1;
                                n_d.oe   = 1'b1;
                                n_d.kind = K_DATA;
                                n_d.st   = S_ACK;
                            end
                        endcase
                    end
                end
                S_ACK: begin
                    if (ev_fall) begin
                        n_d.oe  = 1'b0;
                        n_d.cnt = '0;
                        if (n_q.kind == K_ADDR && n_q.rd) begin
                            n_d.sh = tx_val;
                            n_d.oe = ~tx_val[BYTE_W-1];
                            n_d.st = S_TX;
                        end else if (n_q.kind == K_ADDR) begin
                            n_d.st = S_INSTR;
                        end else if (n_q.kind == K_INSTR) begin
                            n_d.st = S_DATA;
                        end else begin
                            n_d.st = S_HALT;
                        end
                    end
                end
                S_TX: begin
                    if (ev_fall) begin
                        if (n_q.cnt == CNT_W'(BYTE_W - 1)) begin
                            n_d.oe  = 1'b0;
                            n_d.cnt = '0;
                            n_d.st  = S_MACK;
                        end else begin
                            n_d.cnt = n_q.cnt + 1'b1;
                            n_d.sh  = {n_q.sh[BYTE_W-2:0], 1'b0};
                            n_d.oe  = ~n_q.sh[BYTE_W-2];
                        end
                    end
                end
                S_MACK: begin
                    if (ev_rise) begin
                        n_d.mack = ~sda_at;
                    end else if (ev_fall) begin
                        if (n_q.mack) begin
                            n_d.sh  = tx_val;
                            n_d.oe  = ~tx_val[BYTE_W-1];
                            n_d.cnt = '0;
                            n_d.st  = S_TX;
                        end else begin
                            n_d.st = S_HALT;
                        end
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            n_q <= '{st: S_IDLE, kind: K_ADDR, rd: 1'b0, cnt: '0, sh: '0,
                     oe: 1'b0, mack: 1'b0, ch: 1'b0, sd: 1'b0, istb: 1'b0,
                     wstb: 1'b0, wdat: '0};
        end else begin
            n_q <= n_d;
        end
    end

    assign sda_oe    = n_q.oe;
    assign sel_ch    = n_q.ch;
    assign shdn      = n_q.sd;
    assign instr_stb = n_q.istb;
    assign wr_stb    = n_q.wstb;
    assign wr_data   = n_q.wdat;

    a_r5_instr_single: assert property (@(posedge clk) disable iff (!rst_n)
        n_q.istb |=> !n_q.istb);

    a_r6_write_single: assert property (@(posedge clk) disable iff (!rst_n)
        n_q.wstb |=> !n_q.wstb);

    a_r6_write_acked: assert property (@(posedge clk) disable iff (!rst_n)
        n_q.wstb |-> n_q.oe);

    a_r2_stop_releases: assert property (@(posedge clk) disable iff (!rst_n)
        ev_stop |=> !n_q.oe);

    // R3: the drive moves only while the filtered clock is low, except on START/STOP
    a_r3_drive_on_low_scl: assert property (@(posedge clk) disable iff (!rst_n)
        (!$stable(n_q.oe) && !$past(ev_stop) && !$past(ev_start)) |-> !scl_at);

endmodule

// File: rtl/dpot_i2c_front.sv
module dpot_i2c_front
    import dpot_i2c_pkg::*;
#(
    parameter logic [6:0] DEV_ADDR   = 7'b0101111,
    parameter int         GLITCH_CYC = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_i,
    input  logic              sda_i,
    output logic              sda_oe,
    input  logic [BYTE_W-1:0] val0_i,
    input  logic [BYTE_W-1:0] val1_i,
    output logic              sel_ch,
    output logic              shdn,
    output logic              instr_stb,
    output logic              wr_stb,
    output logic [BYTE_W-1:0] wr_data
);
    localparam int NPIN = 2;

    logic [NPIN-1:0] pin_raw;
    logic [NPIN-1:0] pin_lvl;
    logic ev_rise, ev_fall, ev_start, ev_stop, sda_at, scl_at;

    assign pin_raw = {scl_i, sda_i};

    for (genvar g = 0; g < NPIN; g++) begin : g_pin
        i2c_pin_filter #(.GLITCH_CYC(GLITCH_CYC)) u_flt (
            .clk   (clk),
            .rst_n (rst_n),
            .pin_i (pin_raw[g]),
            .lvl_o (pin_lvl[g])
        );
    end

    i2c_bus_events u_evt (
        .clk      (clk),
        .rst_n    (rst_n),
        .scl_l    (pin_lvl[1]),
        .sda_l    (pin_lvl[0]),
        .ev_rise  (ev_rise),
        .ev_fall  (ev_fall),
        .ev_start (ev_start),
        .ev_stop  (ev_stop),
        .sda_at   (sda_at),
        .scl_at   (scl_at)
    );

    dpot_cmd_fsm #(.DEV_ADDR(DEV_ADDR)) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .ev_rise   (ev_rise),
        .ev_fall   (ev_fall),
        .ev_start  (ev_start),
        .ev_stop   (ev_stop),
        .sda_at    (sda_at),
        .scl_at    (scl_at),
        .val0_i    (val0_i),
        .val1_i    (val1_i),
        .sda_oe    (sda_oe),
        .sel_ch    (sel_ch),
        .shdn      (shdn),
        .instr_stb (instr_stb),
        .wr_stb    (wr_stb),
        .wr_data   (wr_data)
    );

endmodule

// File: tb/sim_dpot_i2c_front.sv
`timescale 1ns/1ps
module sim_dpot_i2c_front;
    localparam int Q = 25;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic scl_m = 1'b1;
    logic sda_m = 1'b1;
    logic sda_oe, sel_ch, shdn, instr_stb, wr_stb;
    logic [7:0] wr_data;
    logic [7:0] val0 = 8'hC3;
    logic [7:0] val1 = 8'h5A;
    logic sda_line;

    int n_chk = 0;
    int n_err = 0;
    int wr_cnt = 0;
    int instr_cnt = 0;
    logic [7:0] wr_last = 8'h00;
    logic wr_ch_last = 1'b0;
    logic finished = 1'b0;

    always #2 clk = ~clk;

    assign sda_line = sda_m & ~sda_oe;

    dpot_i2c_front u0 (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_i     (scl_m),
        .sda_i     (sda_line),
        .sda_oe    (sda_oe),
        .val0_i    (val0),
        .val1_i    (val1),
        .sel_ch    (sel_ch),
        .shdn      (shdn),
        .instr_stb (instr_stb),
        .wr_stb    (wr_stb),
        .wr_data   (wr_data)
    );

    always @(negedge clk) begin
        if (rst_n && wr_stb) begin
            wr_cnt     <= wr_cnt + 1;
            wr_last    <= wr_data;
            wr_ch_last <= sel_ch;
        end
        if (rst_n && instr_stb) instr_cnt <= instr_cnt + 1;
    end

    task automatic tick(input int n);
        repeat (n) @(posedge clk);
    endtask

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic bus_start();
        tick(Q); sda_m = 1'b1;
        tick(Q); scl_m = 1'b1;
        tick(Q); sda_m = 1'b0;
        tick(Q); scl_m = 1'b0;
    endtask

    task automatic bus_stop();
        tick(Q); sda_m = 1'b0;
        tick(Q); scl_m = 1'b1;
        tick(Q); sda_m = 1'b1;
        tick(2 * Q);
    endtask

    task automatic clk_bit(input logic b, output logic r);
        tick(Q); sda_m = b;
        tick(Q); scl_m = 1'b1;
        tick(Q); @(negedge clk) r = sda_line;
        tick(Q); scl_m = 1'b0;
    endtask

    // one bit with a short glitch inside the high phase: a low SDA pulse
    // on a 1 bit (would look like START), a low SCL pulse on a 0 bit
    task automatic clk_bit_glitch(input logic b);
        tick(Q); sda_m = b;
        tick(Q); scl_m = 1'b1;
        tick(8);
        if (b) begin
            sda_m = 1'b0; tick(6); sda_m = 1'b1;
        end else begin
            scl_m = 1'b0; tick(6); scl_m = 1'b1;
        end
        tick(2 * Q - 14);
        scl_m = 1'b0;
    endtask

    task automatic send_byte(input logic [7:0] b, output logic ack);
        logic r;
        for (int i = 7; i >= 0; i--) clk_bit(b[i], r);
        clk_bit(1'b1, r);
        ack = ~r;
    endtask

    task automatic recv_byte(input logic m_ack, output logic [7:0] v);
        logic r;
        for (int i = 7; i >= 0; i--) begin
            clk_bit(1'b1, r);
            v[i] = r;
        end
        clk_bit(~m_ack, r);
    endtask

    task automatic t_reset();
        chk("R1 sda_oe", sda_oe, 0);
        chk("R1 sel_ch", sel_ch, 0);
        chk("R1 shdn", shdn, 0);
        chk("R1 wr_stb count", wr_cnt, 0);
        chk("R1 instr_stb count", instr_cnt, 0);
    endtask

    task automatic t_write_basic();
        logic ack, r;
        int w0;
        w0 = wr_cnt;
        bus_start();
        send_byte(8'h5E, ack); chk("R3 write address ack", ack, 1);
        send_byte(8'h15, ack); chk("R5 instruction ack", ack, 1);
        chk("R5 instruction strobe", instr_cnt, 1);
        chk("R5 sel_ch ch0, low bits ignored", sel_ch, 0);
        chk("R5 shdn clear", shdn, 0);
        for (int i = 7; i >= 0; i--) clk_bit(logic'((8'hA5 >> i) & 1), r);
        tick(Q);
        chk("R6 strobe before ack clock", wr_cnt, w0 + 1);
        clk_bit(1'b1, r); chk("R6 data ack", r, 0);
        bus_stop();
        chk("R6 wr_data", wr_last, 8'hA5);
        chk("R6 write channel", wr_ch_last, 0);
    endtask

    task automatic t_write_ch1_sd();
        logic ack;
        bus_start();
        send_byte(8'h5E, ack);
        send_byte(8'hEA, ack); chk("R5 instruction ack ch1", ack, 1);
        send_byte(8'h3C, ack); chk("R6 data ack ch1", ack, 1);
        bus_stop();
        chk("R5 sel_ch ch1", sel_ch, 1);
        chk("R5 shdn set", shdn, 1);
        chk("R6 wr_data ch1", wr_last, 8'h3C);
        chk("R6 write channel ch1", wr_ch_last, 1);
    endtask

    task automatic t_read_nack();
        logic ack;
        logic [7:0] v;
        bus_start();
        send_byte(8'h5F, ack); chk("R3 read address ack", ack, 1);
        recv_byte(1'b0, v); chk("R9 read ch1 value", v, 8'h5A);
        recv_byte(1'b0, v); chk("R10 released after NACK", v, 8'hFF);
        bus_stop();
    endtask

    task automatic t_read_ack();
        logic ack;
        logic [7:0] v;
        bus_start();
        send_byte(8'h5F, ack);
        recv_byte(1'b1, v); chk("R9 first read byte", v, 8'h5A);
        recv_byte(1'b0, v); chk("R10 byte repeated after ACK", v, 8'h5A);
        bus_stop();
    endtask

    task automatic t_instr_only();
        logic ack;
        logic [7:0] v;
        int w0;
        w0 = wr_cnt;
        bus_start();
        send_byte(8'h5E, ack);
        send_byte(8'h00, ack);
        bus_stop();
        chk("R8 sel_ch after short write", sel_ch, 0);
        chk("R8 shdn after short write", shdn, 0);
        chk("R8 no write strobe", wr_cnt, w0);
        bus_start();
        send_byte(8'h5F, ack);
        recv_byte(1'b0, v); chk("R8 read follows new channel", v, 8'hC3);
        bus_stop();
    endtask

    task automatic t_bad_addr();
        logic ack;
        logic [7:0] v;
        int w0, i0;
        w0 = wr_cnt; i0 = instr_cnt;
        bus_start();
        send_byte(8'h5C, ack); chk("R4 no ack on mismatch", ack, 0);
        send_byte(8'h80, ack); chk("R4 no ack on later byte", ack, 0);
        send_byte(8'h11, ack); chk("R4 no ack on third byte", ack, 0);
        bus_stop();
        chk("R4 no write strobe", wr_cnt, w0);
        chk("R4 no instruction strobe", instr_cnt, i0);
        chk("R4 sel_ch kept", sel_ch, 0);
        bus_start();
        send_byte(8'h5D, ack); chk("R4 no ack on read mismatch", ack, 0);
        recv_byte(1'b0, v); chk("R4 bus left released", v, 8'hFF);
        bus_stop();
    endtask

    task automatic t_extra_byte();
        logic ack;
        int w0;
        w0 = wr_cnt;
        bus_start();
        send_byte(8'h5E, ack);
        send_byte(8'h80, ack);
        send_byte(8'h77, ack); chk("R6 data ack", ack, 1);
        send_byte(8'h12, ack); chk("R7 extra byte not acked", ack, 0);
        bus_stop();
        chk("R7 only one write strobe", wr_cnt, w0 + 1);
        chk("R7 wr_data kept", wr_last, 8'h77);
    endtask

    task automatic t_rep_start();
        logic ack, r;
        bus_start();
        send_byte(8'h5E, ack);
        for (int i = 0; i < 4; i++) clk_bit(1'b1, r);
        bus_start();
        send_byte(8'h5E, ack); chk("R11 address after repeated START", ack, 1);
        send_byte(8'h00, ack); chk("R11 instruction ack", ack, 1);
        send_byte(8'h99, ack); chk("R11 data ack", ack, 1);
        bus_stop();
        chk("R11 wr_data", wr_last, 8'h99);
        chk("R11 sel_ch", sel_ch, 0);
    endtask

    task automatic t_glitch();
        logic ack, r;
        int w0;
        w0 = wr_cnt;
        bus_start();
        send_byte(8'h5E, ack);
        send_byte(8'h80, ack);
        for (int i = 7; i >= 0; i--) clk_bit_glitch(logic'((8'h6B >> i) & 1));
        clk_bit(1'b1, r); chk("R12 data ack with glitches", r, 0);
        bus_stop();
        chk("R12 one write strobe", wr_cnt, w0 + 1);
        chk("R12 wr_data with glitches", wr_last, 8'h6B);
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1'b1;
            $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
            $finish;
        end
    endtask

    initial begin
        tick(10);
        rst_n = 1'b1;
        tick(20);
        t_reset();
        t_write_basic();
        t_write_ch1_sd();
        t_read_nack();
        t_read_ack();
        t_instr_only();
        t_bad_addr();
        t_extra_byte();
        t_rep_start();
        t_glitch();
        summary();
    end

    initial begin
        tick(190000);
        n_chk++;
        n_err++;
        $display("FAIL watchdog expired actual=running expected=done");
        summary();
    end

endmodule